// File: doc/BRIEF.md
# Toggle-Handshake Clock-Domain Data Bridge

This block carries one data word at a time from a source clock domain into an unrelated destination clock domain. The two clocks may have any frequency and phase relationship, and the source may be much faster than the destination. The source raises `src_req` for one cycle with a word on `src_data`. A source state machine accepts the request, keeps the word in a holding register and flips a request toggle. The destination sees the toggle through a two-flop synchronizer. It rebuilds a one-cycle pulse by comparing the synchronized level with a one-cycle-delayed copy, and then presents the word with a one-cycle `dst_valid` pulse.

That valid pulse is turned back into a toggle and carried into the source clock through a second synchronizer and edge detector. There it becomes `src_ack` and releases the source. Only the two toggles cross between domains. The data word never passes through a synchronizer: it stays still in the holding register until the acknowledge returns.

Source state machine: `SRC_IDLE` goes to `SRC_WAIT` when a request is accepted (`src_req` high in `SRC_IDLE`). `SRC_WAIT` goes back to `SRC_IDLE` when the acknowledge pulse arrives. Destination state machine: `DST_IDLE` goes to `DST_SHOW` when the regenerated request pulse appears. `DST_SHOW` always goes back to `DST_IDLE` after one cycle.

Top module: `xdom_bridge`

## Requirements
- R1: While either reset is low and right after it is released, `src_busy`, `src_err`, `src_ack` and `dst_valid` are 0 and `dst_data` is all zeros. No pulse appears on any output without a request.
- R2: A request taken in `SRC_IDLE` makes `src_busy` 1 from the next source cycle.
- R3: Each accepted request gives exactly one `dst_valid` pulse, lasting one destination cycle. In that cycle `dst_data` equals the word that was on `src_data` when the request was accepted.
- R4: `dst_data` changes only in a cycle in which `dst_valid` is 1, and otherwise holds the last delivered word.
- R5: Each `dst_valid` pulse yields exactly one one-cycle `src_ack` pulse. `src_ack` occurs only while `src_busy` is 1, and `src_busy` is 0 in the next source cycle.
- R6: A request while `src_busy` is 1 (including the cycle of `src_ack`) is ignored: it produces no delivery and does not change the delivered data. It sets `src_err` from the next cycle, and `src_err` stays 1 until the source reset.
- R7: Transfers complete correctly both when the destination clock is slower than the source clock and when it is faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_req | input | 1 | One-cycle request to send `src_data` |
| src_data | input | DATA_W | Word to transfer, sampled on an accepted request |
| src_busy | output | 1 | Transfer in flight, waiting for acknowledge |
| src_ack | output | 1 | One-cycle pulse: the destination has taken the word |
| src_err | output | 1 | Sticky flag: a request arrived while busy |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle pulse: `dst_data` holds a new word |
| dst_data | output | DATA_W | Last delivered word |

## Verification
The bound checker watches the rules local to each clock on every cycle. Busy rises after an accepted request and falls after the acknowledge. The acknowledge only comes while busy. The valid pulse lasts a single cycle. The delivered word changes only with a valid pulse. The error flag sets on a request while busy and then stays set. The matters that span both domains can only be shown by the bench's scenarios: one delivery per accepted request carrying the right word, one acknowledge per delivery, no trace of a rejected request, and correct delivery with a slower and with a faster destination clock.

// File: rtl/xdom_bridge_pkg.sv
package xdom_bridge_pkg;
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_WAIT = 1'b1
    } src_state_t;

    typedef enum logic {
        DST_IDLE = 1'b0,
        DST_SHOW = 1'b1
    } dst_state_t;
endpackage

// File: rtl/xdom_pulse_to_level.sv
// Flips a level on every single-cycle pulse.
module xdom_pulse_to_level (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     level <= 1'b0;
        else if (pulse) level <= ~level;
    end
endmodule

// File: rtl/xdom_level_sync.sv
// Chain of flip-flops in the receiving clock; STAGES >= 2.
module xdom_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;
    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];
endmodule

// File: rtl/xdom_level_to_pulse.sv
// One-cycle pulse on every change of a synchronized level.
module xdom_level_to_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign pulse = level ^ level_q;
endmodule

// File: rtl/xdom_bridge.sv
module xdom_bridge
    import xdom_bridge_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_req,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    output logic              src_ack,
    output logic              src_err,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);
    // ---------------- source domain ----------------
    src_state_t        src_state, src_next;
    logic [DATA_W-1:0] src_hold;
    logic              take_req;
    logic              req_lvl;
    logic              ack_lvl_sync;

    assign take_req = (src_state == SRC_IDLE) && src_req;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) src_state <= SRC_IDLE;
        else            src_state <= src_next;
    end

    always_comb begin
        src_next = src_state;
        unique case (src_state)
            SRC_IDLE: if (src_req) src_next = SRC_WAIT;
            SRC_WAIT: if (src_ack) src_next = SRC_IDLE;
        endcase
    end

    always_comb begin
        src_busy = (src_state == SRC_WAIT);
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            src_hold <= '0;
            src_err  <= 1'b0;
        end else begin
            if (take_req)                          src_hold <= src_data;
            if (src_req && src_state == SRC_WAIT)  src_err  <= 1'b1;
        end
    end

    xdom_pulse_to_level u_req_tog (
        .clk(src_clk), .rst_n(src_rst_n), .pulse(take_req), .level(req_lvl)
    );

    // ---------------- destination domain ----------------
    dst_state_t dst_state, dst_next;
    logic       req_lvl_sync;
    logic       req_pulse;
    logic       ack_lvl;

    xdom_level_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req_lvl), .q(req_lvl_sync)
    );

    xdom_level_to_pulse u_req_edge (
        .clk(dst_clk), .rst_n(dst_rst_n), .level(req_lvl_sync), .pulse(req_pulse)
    );

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) dst_state <= DST_IDLE;
        else            dst_state <= dst_next;
    end

    always_comb begin
        dst_next = dst_state;
        unique case (dst_state)
            DST_IDLE: if (req_pulse) dst_next = DST_SHOW;
            DST_SHOW: dst_next = DST_IDLE;
        endcase
    end

    always_comb begin
        dst_valid = (dst_state == DST_SHOW);
    end

    // Holding register is steady here: it changed before the toggle crossed.
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n)     dst_data <= '0;
        else if (req_pulse) dst_data <= src_hold;
    end

    xdom_pulse_to_level u_ack_tog (
        .clk(dst_clk), .rst_n(dst_rst_n), .pulse(dst_valid), .level(ack_lvl)
    );

    // ---------------- return path ----------------
    xdom_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(ack_lvl), .q(ack_lvl_sync)
    );

    xdom_level_to_pulse u_ack_edge (
        .clk(src_clk), .rst_n(src_rst_n), .level(ack_lvl_sync), .pulse(src_ack)
    );
endmodule

// File: rtl/xdom_bridge_checker.sv
module xdom_bridge_checker #(
    parameter int DATA_W = 8
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              src_req,
    input logic              src_busy,
    input logic              src_ack,
    input logic              src_err,
    input logic              dst_clk,
    input logic              dst_rst_n,
    input logic              dst_valid,
    input logic [DATA_W-1:0] dst_data
);
    assert_busy_on_accept_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req && !src_busy) |=> src_busy);

    assert_valid_single_R3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid);

    assert_data_hold_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(dst_data) |-> dst_valid);

    assert_ack_when_busy_R5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_ack |-> src_busy);

    assert_busy_clear_R5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_ack |=> !src_busy);

    assert_err_set_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req && src_busy) |=> src_err);

    assert_err_sticky_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_err |=> src_err);
endmodule

bind xdom_bridge xdom_bridge_checker #(.DATA_W(DATA_W)) u_checker (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_req(src_req),
    .src_busy(src_busy), .src_ack(src_ack), .src_err(src_err),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
    .dst_data(dst_data)
);

// File: tb/xdom_bridge_bench.sv
`timescale 1ns/1ps
module xdom_bridge_bench;
    localparam int W = 8;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         src_req = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_busy, src_ack, src_err, dst_valid;
    logic [W-1:0] dst_data;

    real dst_half = 7.0;
    int  checks = 0;
    int  fails = 0;
    int  accepted = 0;
    int  delivered = 0;
    int  acks = 0;
    logic [W-1:0] expq[$];
    logic [W-1:0] prev_data = '0;
    bit           ack_seen = 0;

    always #2 src_clk = ~src_clk;              // 250 MHz source
    always #(dst_half) dst_clk = ~dst_clk;

    xdom_bridge #(.DATA_W(W)) u_xdom_bridge (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_req(src_req),
        .src_data(src_data), .src_busy(src_busy), .src_ack(src_ack),
        .src_err(src_err), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: destination deliveries against scoreboard (R3, R4)
    always @(negedge dst_clk) begin
        if (!dst_rst_n) begin
            prev_data = '0;
        end else begin
            if (dst_valid) begin
                delivered++;
                if (expq.size() == 0) begin
                    check(0, "R3 unexpected delivery", dst_data, 0);
                end else begin
                    logic [W-1:0] e;
                    e = expq.pop_front();
                    check(dst_data == e, "R3 delivered word", dst_data, e);
                end
            end else if (dst_data != prev_data) begin
                check(0, "R4 data changed without valid", dst_data, prev_data);
            end
            prev_data = dst_data;
        end
    end

    // Monitor: acknowledge behaviour (R5)
    always @(negedge src_clk) begin
        if (!src_rst_n) begin
            ack_seen = 0;
        end else begin
            if (ack_seen) begin
                check(src_busy == 1'b0, "R5 busy clears after ack", src_busy, 0);
                check(src_ack == 1'b0, "R5 ack lasts one cycle", src_ack, 0);
            end
            ack_seen = 0;
            if (src_ack) begin
                acks++;
                ack_seen = 1;
                check(src_busy == 1'b1, "R5 ack only while busy", src_busy, 1);
            end
        end
    end

    task automatic wait_idle();
        @(negedge src_clk);
        while (src_busy) @(negedge src_clk);
    endtask

    task automatic send(input logic [W-1:0] d);
        wait_idle();
        src_req  = 1'b1;
        src_data = d;
        expq.push_back(d);
        accepted++;
        @(negedge src_clk);
        src_req  = 1'b0;
        src_data = ~d;                       // holding register must keep d
        check(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
    endtask

    task automatic do_reset();
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_req   = 1'b0;
        repeat (4) @(negedge dst_clk);
        @(negedge src_clk);
        check(src_busy == 0 && src_err == 0 && src_ack == 0, "R1 source outputs in reset",
              {src_busy, src_err, src_ack}, 0);
        check(dst_valid == 0 && dst_data == '0, "R1 destination outputs in reset",
              {dst_valid, dst_data}, 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (10) @(negedge src_clk);
        check(src_busy == 0 && src_err == 0 && src_ack == 0 && dst_valid == 0,
              "R1 quiet after reset", {src_busy, src_err, src_ack, dst_valid}, 0);
    endtask

    initial begin
        #400us;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        check(delivered == 0, "R1 no delivery without request", delivered, 0);

        // R7: destination slower than source
        dst_half = 7.0;
        foreach (expq[i]) begin end
        for (int i = 0; i < 6; i++) send(8'h10 + 8'(i * 37));
        send(8'h00);
        send(8'hFF);
        wait_idle();
        repeat (40) @(negedge src_clk);
        check(delivered == accepted, "R7 slow destination all delivered", delivered, accepted);
        check(acks == delivered, "R5 one ack per delivery", acks, delivered);
        check(src_err == 0, "R6 no error without overlap", src_err, 0);

        // R6: request while busy is ignored and flags error
        send(8'hA5);
        src_req  = 1'b1;
        src_data = 8'hEE;
        @(negedge src_clk);
        src_req  = 1'b0;
        check(src_err == 1'b1, "R6 error set on busy request", src_err, 1);
        wait_idle();
        repeat (60) @(negedge src_clk);
        check(delivered == accepted, "R6 busy request not delivered", delivered, accepted);
        check(dst_data == 8'hA5, "R6 delivered data untouched", dst_data, 8'hA5);

        // R7: destination faster than source; error stays set
        dst_half = 1.3;
        repeat (4) @(negedge src_clk);
        for (int i = 0; i < 8; i++) send(8'(i * 29 + 3));
        wait_idle();
        repeat (40) @(negedge src_clk);
        check(delivered == accepted, "R7 fast destination all delivered", delivered, accepted);
        check(acks == delivered, "R5 ack count fast destination", acks, delivered);
        check(expq.size() == 0, "R3 scoreboard empty", expq.size(), 0);
        check(src_err == 1'b1, "R6 error sticky", src_err, 1);

        // R6: only reset clears the error flag
        do_reset();
        check(src_err == 1'b0, "R6 error cleared by reset", src_err, 0);
        send(8'h5A);
        wait_idle();
        repeat (40) @(negedge src_clk);
        check(dst_data == 8'h5A, "R3 transfer after reset", dst_data, 8'h5A);
        summary();
    end
endmodule